// File: doc/BRIEF.md
# Quadword Load into an Even/Odd Register Pair

This block carries out one load-quadword operation. It takes a target pair index, a base register index, a 12-bit scaled displacement, the value of the base register and an endian-mode bit. It checks the instruction form, adds the scaled offset to the base to get the effective address, and issues one 16-byte read on a valid/ready request channel. When the 128-bit response arrives, it splits the data into two 64-bit writebacks: one for the even register of the pair and one for the odd register.

In big-endian mode the two halves of the response go straight to the even and odd registers. In little-endian mode the halves are swapped between the two registers and each one is byte-reversed. An invalid form issues no memory traffic and writes no register. Instead it raises a one-cycle illegal-instruction pulse. The block handles one operation at a time and changes no status state.

Top module: `qw_pair_load`

## Requirements
- R1: The address on `mem_req_addr` equals the base term plus the displacement with four zero bits appended below it, sign-extended to 64 bits. The offset therefore runs from -32768 to +32752, and the sum wraps modulo 2^64.
- R2: When `ins_ra` is 0, the base term is zero, whatever the value on `base_val`.
- R3: A valid form issues exactly one memory request. The response word carries bytes EA through EA+15, with byte EA in bits [127:120].
- R4: An odd `ins_rt` is invalid. `illegal` is high for exactly the one cycle after acceptance. No request is issued and no writeback occurs.
- R5: `ins_rt` equal to `ins_ra` is invalid and is handled as in R4. This includes the case where both are 0.
- R6: When `le_mode`=0 at acceptance, the even register receives `mem_rsp_data[127:64]` and the odd register receives `mem_rsp_data[63:0]`, both unchanged.
- R7: When `le_mode`=1, the even register receives `mem_rsp_data[63:0]` with its byte order reversed, and the odd register receives `mem_rsp_data[127:64]` with its byte order reversed.
- R8: Both write enables are high together for exactly the one cycle after the response handshake. The even index equals `ins_rt` and the odd index equals `ins_rt`+1.
- R9: `ins_ready` goes low on the cycle after acceptance. It stays low until the writeback cycle or the illegal cycle has completed.
- R10: After reset, `ins_ready`=1 and `mem_req_valid`, `mem_rsp_ready`, both write enables and `illegal` are all 0.
- R11: While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Operation offered |
| ins_ready | output | 1 | Block idle and able to accept |
| ins_rt | input | 5 | Target pair index (must be even) |
| ins_ra | input | 5 | Base register index (0 selects a zero base) |
| ins_disp | input | 12 | Signed displacement in 16-byte units |
| le_mode | input | 1 | 1 selects little-endian routing |
| base_val | input | 64 | Contents of the base register |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Effective address of the 16-byte read |
| mem_rsp_valid | input | 1 | Response data valid |
| mem_rsp_ready | output | 1 | Block waiting for the response |
| mem_rsp_data | input | 128 | Bytes EA..EA+15, with EA most significant |
| wb_even_en | output | 1 | Even-register write enable |
| wb_even_idx | output | 5 | Even register index |
| wb_even_data | output | 64 | Even register data |
| wb_odd_en | output | 1 | Odd-register write enable |
| wb_odd_idx | output | 5 | Odd register index |
| wb_odd_data | output | 64 | Odd register data |
| illegal | output | 1 | One-cycle invalid-form pulse |

## Verification
The bench sends `ins_ra`=0 with a non-zero `base_val`. A design that read register 0 would put the wrong address on the request. It drives both extreme displacements and bases that wrap, which exposes a missing sign extension or a wrong shift. It also covers `ins_rt`=`ins_ra`=0, `ins_rt`=`ins_ra`≠0 and odd targets. A form check that missed one of these would issue a read or write registers instead of pulsing `illegal`. In little-endian mode, random response data shows whether the halves are swapped and the bytes reversed. Random stalls on both handshakes test that the request holds steady and that the writeback waits for the response.

// File: rtl/qwl_pkg.sv
// Package: shared widths and the sequencer state type for the quadword pair load.
// Assumes a 64-bit register width, 32 registers and a 16-byte scaled displacement.
package qwl_pkg;
    parameter int XLEN       = 64;
    parameter int RIDX_W     = 5;
    parameter int DISP_W     = 12;
    parameter int DISP_SHIFT = 4;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ILL  = 3'd1,
        S_REQ  = 3'd2,
        S_RSP  = 3'd3,
        S_WB   = 3'd4
    } qwl_state_t;
endpackage

// File: rtl/qwl_ea_form.sv
// Module: effective-address adder and form check.
// Purely combinational. Index 0 in the base field selects a zero base.
// A form is bad when the target index is odd or equals the base index.
module qwl_ea_form #(
    parameter int XLEN       = 64,
    parameter int RIDX_W     = 5,
    parameter int DISP_W     = 12,
    parameter int DISP_SHIFT = 4
) (
    input  logic [RIDX_W-1:0] rt,
    input  logic [RIDX_W-1:0] ra,
    input  logic [DISP_W-1:0] disp,
    input  logic [XLEN-1:0]   base,
    output logic [XLEN-1:0]   ea,
    output logic              bad_form
);
    localparam int EXT_W = XLEN - DISP_W - DISP_SHIFT;

    logic [XLEN-1:0] base_term;
    logic [XLEN-1:0] offset;

    // Base select: index 0 reads as the constant zero.
    always_comb base_term = (ra == '0) ? '0 : base;

    // Scaled, sign-extended displacement.
    always_comb offset = {{EXT_W{disp[DISP_W-1]}}, disp, {DISP_SHIFT{1'b0}}};

    // Address sum, wrapping at the register width.
    always_comb ea = base_term + offset;

    // Invalid when the pair index is odd or overlaps the base index.
    always_comb bad_form = rt[0] | (rt == ra);
endmodule

// File: rtl/qwl_lane_swap.sv
// Module: splits a 128-bit response into the even and odd register values.
// Big-endian: the upper half goes to even and the lower half to odd.
// Little-endian: the halves are crossed and each is byte-reversed.
module qwl_lane_swap #(
    parameter int XLEN = 64
) (
    input  logic              le,
    input  logic [2*XLEN-1:0] line,
    output logic [XLEN-1:0]   even_q,
    output logic [XLEN-1:0]   odd_q
);
    localparam int NBYTES = XLEN / 8;

    logic [XLEN-1:0] hi_half;
    logic [XLEN-1:0] lo_half;
    logic [XLEN-1:0] hi_rev;
    logic [XLEN-1:0] lo_rev;

    // Half extraction.
    always_comb begin
        hi_half = line[2*XLEN-1:XLEN];
        lo_half = line[XLEN-1:0];
    end

    // Byte reversal network for both halves.
    for (genvar b = 0; b < NBYTES; b++) begin : g_rev
        assign hi_rev[8*b +: 8] = hi_half[8*(NBYTES-1-b) +: 8];
        assign lo_rev[8*b +: 8] = lo_half[8*(NBYTES-1-b) +: 8];
    end

    // Mode-dependent routing to the pair.
    always_comb begin
        if (le) begin
            even_q = lo_rev;
            odd_q  = hi_rev;
        end else begin
            even_q = hi_half;
            odd_q  = lo_half;
        end
    end
endmodule

// File: rtl/qwl_seq.sv
// Module: single-outstanding sequencer for the pair load.
// Accepts in IDLE. A bad form goes to one ILL cycle. A good form requests,
// waits for the response, then writes back for one cycle.
// Latches address, target, mode and response data on their handshakes.
module qwl_seq #(
    parameter int XLEN   = 64,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic              bad_form,
    input  logic [XLEN-1:0]   ea_in,
    input  logic [RIDX_W-1:0] rt_in,
    input  logic              le_in,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [XLEN-1:0]   req_addr,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [2*XLEN-1:0] rsp_data,
    output logic              wb_en,
    output logic              ill_pulse,
    output logic [RIDX_W-1:0] rt_q,
    output logic              le_q,
    output logic [2*XLEN-1:0] line_q
);
    import qwl_pkg::*;

    qwl_state_t state;
    logic [XLEN-1:0] ea_q;
    logic accept;

    // Handshake decode for the instruction side.
    always_comb accept = acc_valid && (state == S_IDLE);

    // State transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            case (state)
                S_IDLE:  if (accept) state <= bad_form ? S_ILL : S_REQ;
                S_ILL:   state <= S_IDLE;
                S_REQ:   if (req_ready) state <= S_RSP;
                S_RSP:   if (rsp_valid) state <= S_WB;
                S_WB:    state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Capture the operation fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q <= '0;
            rt_q <= '0;
            le_q <= 1'b0;
        end else if (accept) begin
            ea_q <= ea_in;
            rt_q <= rt_in;
            le_q <= le_in;
        end
    end

    // Capture the response word on its handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else if (state == S_RSP && rsp_valid) line_q <= rsp_data;
    end

    // Output decode from the state.
    always_comb begin
        acc_ready = (state == S_IDLE);
        req_valid = (state == S_REQ);
        rsp_ready = (state == S_RSP);
        wb_en     = (state == S_WB);
        ill_pulse = (state == S_ILL);
        req_addr  = ea_q;
    end

    // R11: a stalled request keeps its valid and its address.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    // R8: a writeback follows a response handshake.
    p_wb_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(rsp_valid && rsp_ready));

    // R9: after acceptance the block is busy.
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> !acc_ready);

    // R4: the illegal pulse lasts one cycle.
    p_ill_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ill_pulse |=> !ill_pulse);

    // R4: no request and no writeback during the illegal cycle.
    p_ill_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ill_pulse |-> (!req_valid && !wb_en));
endmodule

// File: rtl/qw_pair_load.sv
// Module: quadword load into an even/odd register pair (top).
// Computes the effective address and checks the form, then issues one 16-byte read.
// The response is routed to two 64-bit writebacks according to the endian mode.
// Assumes memory returns byte EA in the top byte of the response word.
module qw_pair_load #(
    parameter int XLEN       = qwl_pkg::XLEN,
    parameter int RIDX_W     = qwl_pkg::RIDX_W,
    parameter int DISP_W     = qwl_pkg::DISP_W,
    parameter int DISP_SHIFT = qwl_pkg::DISP_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ins_valid,
    output logic                ins_ready,
    input  logic [RIDX_W-1:0]   ins_rt,
    input  logic [RIDX_W-1:0]   ins_ra,
    input  logic [DISP_W-1:0]   ins_disp,
    input  logic                le_mode,
    input  logic [XLEN-1:0]     base_val,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [XLEN-1:0]     mem_req_addr,
    input  logic                mem_rsp_valid,
    output logic                mem_rsp_ready,
    input  logic [2*XLEN-1:0]   mem_rsp_data,
    output logic                wb_even_en,
    output logic [RIDX_W-1:0]   wb_even_idx,
    output logic [XLEN-1:0]     wb_even_data,
    output logic                wb_odd_en,
    output logic [RIDX_W-1:0]   wb_odd_idx,
    output logic [XLEN-1:0]     wb_odd_data,
    output logic                illegal
);
    logic [XLEN-1:0]   ea_w;
    logic              bad_w;
    logic              wb_en_w;
    logic [RIDX_W-1:0] rt_q;
    logic              le_q;
    logic [2*XLEN-1:0] line_q;

    qwl_ea_form #(
        .XLEN(XLEN), .RIDX_W(RIDX_W), .DISP_W(DISP_W), .DISP_SHIFT(DISP_SHIFT)
    ) u_ea (
        .rt(ins_rt), .ra(ins_ra), .disp(ins_disp), .base(base_val),
        .ea(ea_w), .bad_form(bad_w)
    );

    qwl_seq #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(ins_valid), .acc_ready(ins_ready),
        .bad_form(bad_w), .ea_in(ea_w), .rt_in(ins_rt), .le_in(le_mode),
        .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr),
        .rsp_valid(mem_rsp_valid), .rsp_ready(mem_rsp_ready), .rsp_data(mem_rsp_data),
        .wb_en(wb_en_w), .ill_pulse(illegal),
        .rt_q(rt_q), .le_q(le_q), .line_q(line_q)
    );

    qwl_lane_swap #(.XLEN(XLEN)) u_swap (
        .le(le_q), .line(line_q), .even_q(wb_even_data), .odd_q(wb_odd_data)
    );

    // Writeback enables and pair indices.
    always_comb begin
        wb_even_en  = wb_en_w;
        wb_odd_en   = wb_en_w;
        wb_even_idx = rt_q;
        wb_odd_idx  = {rt_q[RIDX_W-1:1], 1'b1};
    end

    // R5: an overlapping target and base is followed by the illegal pulse.
    p_overlap_ill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && ins_rt == ins_ra) |=> illegal);

    // R4: an odd target is followed by the illegal pulse.
    p_odd_ill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && ins_rt[0]) |=> (illegal && !mem_req_valid));

    // R8: the two writeback enables are never split.
    p_wb_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_even_en |-> (wb_odd_en && !illegal && !mem_req_valid));
endmodule

// File: tb/sim_qw_pair_load.sv
module sim_qw_pair_load;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ins_valid = 1'b0;
    logic         ins_ready;
    logic [4:0]   ins_rt = '0;
    logic [4:0]   ins_ra = '0;
    logic [11:0]  ins_disp = '0;
    logic         le_mode = 1'b0;
    logic [63:0]  base_val = '0;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [63:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic         mem_rsp_ready;
    logic [127:0] mem_rsp_data = '0;
    logic         wb_even_en, wb_odd_en;
    logic [4:0]   wb_even_idx, wb_odd_idx;
    logic [63:0]  wb_even_data, wb_odd_data;
    logic         illegal;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    qw_pair_load u0 (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_rt(ins_rt), .ins_ra(ins_ra), .ins_disp(ins_disp), .le_mode(le_mode),
        .base_val(base_val), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
        .wb_even_en(wb_even_en), .wb_even_idx(wb_even_idx), .wb_even_data(wb_even_data),
        .wb_odd_en(wb_odd_en), .wb_odd_idx(wb_odd_idx), .wb_odd_data(wb_odd_data),
        .illegal(illegal)
    );

    function automatic logic [63:0] f_ea(logic [63:0] b, logic [4:0] ra, logic [11:0] d);
        logic [63:0] off;
        off = {{48{d[11]}}, d, 4'b0000};
        return ((ra == 5'd0) ? 64'd0 : b) + off;
    endfunction

    function automatic logic [63:0] f_rev(logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
        return r;
    endfunction

    function automatic logic [63:0] f_even(logic [127:0] w, logic le);
        return le ? f_rev(w[63:0]) : w[127:64];
    endfunction

    function automatic logic [63:0] f_odd(logic [127:0] w, logic le);
        return le ? f_rev(w[127:64]) : w[63:0];
    endfunction

    task automatic chk(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Runs one operation end to end; samples at negedges.
    task automatic run_op(input logic [4:0] rt, input logic [4:0] ra,
                          input logic [11:0] d, input logic [63:0] b, input logic le,
                          input int req_stall, input int rsp_stall,
                          input logic [127:0] data);
        logic inv;
        logic [63:0] ea;
        inv = rt[0] || (rt == ra);
        ea  = f_ea(b, ra, d);
        ins_rt = rt; ins_ra = ra; ins_disp = d; base_val = b; le_mode = le;
        ins_valid = 1'b1;
        @(negedge clk);
        ins_valid = 1'b0;
        chk(ins_ready == 1'b0, "R9 busy after accept", ins_ready, 0);
        if (inv) begin
            chk(illegal == 1'b1, rt[0] ? "R4 odd illegal" : "R5 overlap illegal", illegal, 1);
            chk(mem_req_valid == 1'b0 && wb_even_en == 1'b0, "R4 quiet on invalid",
                {mem_req_valid, wb_even_en}, 0);
            @(negedge clk);
            chk(illegal == 1'b0, "R4 pulse one cycle", illegal, 0);
            chk(ins_ready == 1'b1 && mem_req_valid == 1'b0, "R9 ready after illegal",
                {ins_ready, mem_req_valid}, 2'b10);
        end else begin
            chk(mem_req_valid == 1'b1 && illegal == 1'b0, "R3 request issued",
                {mem_req_valid, illegal}, 2'b10);
            chk(mem_req_addr == ea, (ra == 0) ? "R2 zero base addr" : "R1 ea", mem_req_addr, ea);
            for (int s = 0; s < req_stall; s++) begin
                @(negedge clk);
                chk(mem_req_valid == 1'b1 && mem_req_addr == ea, "R11 hold stalled request",
                    mem_req_addr, ea);
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            chk(mem_req_valid == 1'b0 && mem_rsp_ready == 1'b1, "R3 single request",
                {mem_req_valid, mem_rsp_ready}, 2'b01);
            for (int s = 0; s < rsp_stall; s++) begin
                @(negedge clk);
                chk(wb_even_en == 1'b0 && mem_req_valid == 1'b0, "R8 no early writeback",
                    {wb_even_en, mem_req_valid}, 0);
            end
            mem_rsp_valid = 1'b1;
            mem_rsp_data = data;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            chk(wb_even_en && wb_odd_en, "R8 both enables", {wb_even_en, wb_odd_en}, 2'b11);
            chk(wb_even_idx == rt && wb_odd_idx == rt + 5'd1, "R8 pair indices",
                {wb_even_idx, wb_odd_idx}, {rt, rt + 5'd1});
            chk(wb_even_data == f_even(data, le), le ? "R7 LE even" : "R6 BE even",
                wb_even_data, f_even(data, le));
            chk(wb_odd_data == f_odd(data, le), le ? "R7 LE odd" : "R6 BE odd",
                wb_odd_data, f_odd(data, le));
            @(negedge clk);
            chk(!wb_even_en && !wb_odd_en && ins_ready, "R8 one cycle, R9 ready again",
                {wb_even_en, wb_odd_en, ins_ready}, 3'b001);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(ins_ready == 1'b1 && !mem_req_valid && !mem_rsp_ready && !wb_even_en &&
            !wb_odd_en && !illegal, "R10 reset state",
            {ins_ready, mem_req_valid, mem_rsp_ready, wb_even_en, wb_odd_en, illegal},
            6'b100000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ins_ready == 1'b1 && !illegal, "R10 idle after reset", ins_ready, 1);

        // Directed corner cases.
        run_op(5'd4, 5'd0, 12'h010, 64'hDEAD_BEEF_0000_0000, 1'b0, 0, 0, rnd128()); // R2
        run_op(5'd2, 5'd7, 12'h7FF, 64'h1000, 1'b0, 2, 1, rnd128());                 // R1 max
        run_op(5'd6, 5'd3, 12'h800, 64'h1_0000, 1'b1, 0, 3, rnd128());               // R1 min
        run_op(5'd8, 5'd1, 12'h001, 64'hFFFF_FFFF_FFFF_FFF8, 1'b1, 1, 0, rnd128());   // R1 wrap
        run_op(5'd0, 5'd0, 12'h000, 64'h40, 1'b0, 0, 0, rnd128());                    // R5 both 0
        run_op(5'd10, 5'd10, 12'h003, 64'h80, 1'b1, 0, 0, rnd128());                  // R5
        run_op(5'd3, 5'd9, 12'h003, 64'h80, 1'b0, 0, 0, rnd128());                    // R4
        run_op(5'd30, 5'd2, 12'h020, 64'h5000, 1'b1, 0, 0,
               128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF);                         // R7
        run_op(5'd30, 5'd2, 12'h020, 64'h5000, 1'b0, 0, 0,
               128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF);                         // R6

        // Constrained random operations.
        for (int n = 0; n < 400; n++) begin
            logic [4:0] rt;
            logic [4:0] ra;
            rt = 5'($urandom);
            ra = 5'($urandom);
            if ($urandom % 5 != 0) rt[0] = 1'b0;
            if ($urandom % 8 == 0) ra = rt;
            run_op(rt, ra, 12'($urandom), {$urandom, $urandom}, 1'($urandom),
                   int'($urandom % 4), int'($urandom % 4), rnd128());
            if ($urandom % 3 == 0) @(negedge clk);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule